// File: doc/BRIEF.md
# Power-Up Strap Sampler and Frequency Select Source

This block serves four pins that have two jobs. While the supply settles after reset, each pin is a configuration input. The block holds the pin output drivers off so that the external strap resistors set the level on each pin. A settling counter measures a fixed number of reference clock cycles. When it expires, the block captures the four strap levels as select bits S3..S0 and turns the pin drivers on, so the pins can carry their clock outputs.

After capture, the block presents one 5-bit frequency select code to the synthesizer logic. A mode bit in control byte 0 picks the source of that code. In hardware mode the code is built from the captured straps, with the top bit S4 held at zero. In software mode the code is gathered from five bits spread across control byte 0. The block also decodes the spread-enable and test-mode bits of that byte. It returns the captured straps in inverted form, for a status byte to read back.

Top module: `strap_select`

## Requirements
- R1: While reset is asserted and just after it, `sel_valid_o` is 0, `pin_oe_o` is 4'b0000, and with `ctrl0_i[3]`=0 the code `sel_code_o` is 5'b00000.
- R2: `sel_valid_o` rises exactly SETTLE_CYCLES rising clock edges after reset release. `pin_oe_o` is 4'b0000 before that point and 4'b1111 from that point on.
- R3: The captured straps equal the levels on `strap_pin_i` at the moment of capture, with bit k of `strap_pin_i` taken as select bit Sk. A pin with no strap is driven to 0 and is captured as 0.
- R4: Capture happens once per reset. After capture, changes on `strap_pin_i` do not affect `sel_code_o` or `strap_rb_o`.
- R5: When `ctrl0_i[3]`=0, `sel_code_o` = {1'b0, S3, S2, S1, S0} from the captured straps, with S4 in bit 4. The other bits of `ctrl0_i` do not affect the code.
- R6: When `ctrl0_i[3]`=1, `sel_code_o` bits 4..0 are `ctrl0_i` bits 7, 2, 6, 5, 4 in that order (S4, S3, S2, S1, S0). This holds whether or not capture has happened.
- R7: `strap_rb_o` is the bitwise inverse of the captured S3..S0, with bit k for Sk. Before capture it reads 4'b1111.
- R8: `spread_en_o` follows `ctrl0_i[1]` and `test_mode_o` follows `ctrl0_i[0]`.
- R9: Once `sel_valid_o` is high it stays high until the next reset. A new reset re-arms the counter, and the following capture takes the new strap levels.
- R10: A change of `ctrl0_i` shows up on `sel_code_o` in the same cycle, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pin_i | input | 4 | Pin levels read as straps; bit k is Sk |
| pin_oe_o | output | 4 | Output-driver enable for each dual-purpose pin |
| ctrl0_i | input | 8 | Control byte 0 (source mode, software select, spread, test) |
| sel_code_o | output | 5 | Active frequency select code S4..S0 |
| sel_valid_o | output | 1 | Straps have been captured; stays high until reset |
| strap_rb_o | output | 4 | Inverted captured straps for status readback |
| spread_en_o | output | 1 | Spread spectrum enable |
| test_mode_o | output | 1 | Test mode select |

## Verification
The hardest case to reach from the ports is the single-capture rule. It only shows when the strap pins change after the latch has fired. The stimulus therefore moves the pins after capture and confirms that neither the code nor the readback follows them. It then applies a second reset with a different strap pattern to show that only a reset re-arms the latch. Capture timing is checked at the edge level: the bench counts edges from reset release and samples one edge before expiry and at expiry.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;
   localparam int STRAP_W = 4;
   localparam int CODE_W  = 5;

   // Field positions inside control byte 0 (decoded by neighbours as well)
   localparam int C0_TEST   = 0;
   localparam int C0_SPREAD = 1;
   localparam int C0_SW_S3  = 2;
   localparam int C0_SRC    = 3;
   localparam int C0_SW_S0  = 4;
   localparam int C0_SW_S1  = 5;
   localparam int C0_SW_S2  = 6;
   localparam int C0_SW_S4  = 7;

   typedef logic [STRAP_W-1:0] strap_t;
   typedef logic [CODE_W-1:0]  sel_code_t;

   typedef enum logic {SRC_STRAP = 1'b0, SRC_SOFT = 1'b1} sel_src_e;
endpackage

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
   parameter int SETTLE_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign expire_o = !done_q && (cnt_q == LAST);
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_sel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  strap_t pin_i,
   input  logic   capture_i,
   output strap_t straps_o,
   output logic   valid_o
);
   strap_t sampled;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = pin_i;
      end else begin : g_sync
         strap_t sync_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
            end else begin
               sync_q[0] <= pin_i;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign sampled = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   strap_t latch_q;
   logic   valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         valid_q <= 1'b0;
      end else if (capture_i && !valid_q) begin
         latch_q <= sampled;
         valid_q <= 1'b1;
      end
   end

   assign straps_o = latch_q;
   assign valid_o  = valid_q;
endmodule

// File: rtl/strap_sel_mux.sv
module strap_sel_mux
   import strap_sel_pkg::*;
(
   input  strap_t      straps_i,
   input  logic [7:0]  ctrl0_i,
   output sel_code_t   code_o,
   output strap_t      readback_o,
   output logic        spread_o,
   output logic        test_o
);
   sel_src_e  src;
   sel_code_t hw_code;
   sel_code_t sw_code;

   assign src     = sel_src_e'(ctrl0_i[C0_SRC]);
   assign hw_code = {1'b0, straps_i};
   assign sw_code = {ctrl0_i[C0_SW_S4], ctrl0_i[C0_SW_S3], ctrl0_i[C0_SW_S2],
                     ctrl0_i[C0_SW_S1], ctrl0_i[C0_SW_S0]};

   always_comb begin
      unique case (src)
         SRC_SOFT:  code_o = sw_code;
         default:   code_o = hw_code;
      endcase
   end

   assign readback_o = ~straps_i;
   assign spread_o   = ctrl0_i[C0_SPREAD];
   assign test_o     = ctrl0_i[C0_TEST];
endmodule

// File: rtl/strap_select.sv
module strap_select
   import strap_sel_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4096,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] strap_pin_i,
   output logic [3:0] pin_oe_o,
   input  logic [7:0] ctrl0_i,
   output logic [4:0] sel_code_o,
   output logic       sel_valid_o,
   output logic [3:0] strap_rb_o,
   output logic       spread_en_o,
   output logic       test_mode_o
);
   initial begin
      if (SETTLE_CYCLES < 1)
         $error("SETTLE_CYCLES must be at least 1");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("SYNC_STAGES must lie in 0..4");
      if (SETTLE_CYCLES <= SYNC_STAGES)
         $error("SETTLE_CYCLES must exceed SYNC_STAGES");
   end

   logic   expire;
   logic   timer_done;
   strap_t straps;
   logic   valid;

   strap_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .expire_o(expire), .done_o(timer_done)
   );

   strap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin_i(strap_pin_i), .capture_i(expire),
      .straps_o(straps), .valid_o(valid)
   );

   strap_sel_mux u_mux (
      .straps_i(straps), .ctrl0_i(ctrl0_i), .code_o(sel_code_o),
      .readback_o(strap_rb_o), .spread_o(spread_en_o), .test_o(test_mode_o)
   );

   genvar g;
   generate
      for (g = 0; g < STRAP_W; g++) begin : g_oe
         assign pin_oe_o[g] = valid && timer_done;
      end
   endgenerate

   assign sel_valid_o = valid;
endmodule

// File: rtl/strap_select_chk.sv
module strap_select_chk #(
   parameter int SETTLE_CYCLES = 4096
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] pin_oe_o,
   input logic [7:0] ctrl0_i,
   input logic [4:0] sel_code_o,
   input logic       sel_valid_o,
   input logic [3:0] strap_rb_o
);
   localparam int W = $clog2(SETTLE_CYCLES + 1);
   logic [W-1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != W'(SETTLE_CYCLES)) since_rst <= since_rst + 1'b1;
   end

   a_r2_capture_time: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o == (since_rst == W'(SETTLE_CYCLES)));

   a_r2_oe_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe_o == (sel_valid_o ? 4'hF : 4'h0));

   a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |=> sel_valid_o);

   a_r4_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |=> $stable(strap_rb_o));

   a_r7_rb_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid_o |-> strap_rb_o == 4'hF);

   a_r5_hw_code: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl0_i[3] |-> sel_code_o == {1'b0, ~strap_rb_o});

   a_r6_sw_code: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl0_i[3] |-> sel_code_o == {ctrl0_i[7], ctrl0_i[2], ctrl0_i[6], ctrl0_i[5], ctrl0_i[4]});
endmodule

bind strap_select strap_select_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_oe_o(pin_oe_o), .ctrl0_i(ctrl0_i),
   .sel_code_o(sel_code_o), .sel_valid_o(sel_valid_o), .strap_rb_o(strap_rb_o)
);

// File: tb/tb_strap_select.sv
`timescale 1ns/1ps
module tb_strap_select;
   localparam int N = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] strap_pin_i = 4'h0;
   logic [3:0] pin_oe_o;
   logic [7:0] ctrl0_i = 8'h00;
   logic [4:0] sel_code_o;
   logic       sel_valid_o;
   logic [3:0] strap_rb_o;
   logic       spread_en_o;
   logic       test_mode_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   strap_select #(.SETTLE_CYCLES(N), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .strap_pin_i(strap_pin_i), .pin_oe_o(pin_oe_o),
      .ctrl0_i(ctrl0_i), .sel_code_o(sel_code_o), .sel_valid_o(sel_valid_o),
      .strap_rb_o(strap_rb_o), .spread_en_o(spread_en_o), .test_mode_o(test_mode_o)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply_reset(input logic [3:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      strap_pin_i = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      ctrl0_i = 8'h00;
      apply_reset(4'h0);
      #1;
      check(sel_valid_o == 1'b0, "R1 valid", 8'(sel_valid_o), 8'h0);
      check(pin_oe_o == 4'h0, "R1 oe", 8'(pin_oe_o), 8'h0);
      check(sel_code_o == 5'h00, "R1 code", 8'(sel_code_o), 8'h0);
      check(strap_rb_o == 4'hF, "R7 rb before capture", 8'(strap_rb_o), 8'hF);
   endtask

   task automatic t_settle(input logic [3:0] s);
      apply_reset(s);
      repeat (N-1) @(posedge clk);
      #1;
      check(sel_valid_o == 1'b0, "R2 valid one edge early", 8'(sel_valid_o), 8'h0);
      check(pin_oe_o == 4'h0, "R2 oe one edge early", 8'(pin_oe_o), 8'h0);
      @(posedge clk);
      #1;
      check(sel_valid_o == 1'b1, "R2 valid at expiry", 8'(sel_valid_o), 8'h1);
      check(pin_oe_o == 4'hF, "R2 oe at expiry", 8'(pin_oe_o), 8'hF);
      check(strap_rb_o == ~s, "R3 R7 captured inverted", 8'(strap_rb_o), 8'(~s));
   endtask

   task automatic t_hw_mode(input logic [3:0] s);
      ctrl0_i = 8'hF7;  // source bit 3 clear, all others set
      #1;
      check(sel_code_o == {1'b0, s}, "R5 hw code", 8'(sel_code_o), 8'({1'b0, s}));
      ctrl0_i = 8'h00;
      #1;
      check(sel_code_o == {1'b0, s}, "R5 hw code quiet ctrl", 8'(sel_code_o), 8'({1'b0, s}));
   endtask

   task automatic t_frozen(input logic [3:0] s);
      ctrl0_i = 8'h00;
      @(negedge clk);
      strap_pin_i = ~s;
      repeat (6) @(negedge clk);
      check(sel_code_o == {1'b0, s}, "R4 code ignores pins", 8'(sel_code_o), 8'({1'b0, s}));
      check(strap_rb_o == ~s, "R4 rb ignores pins", 8'(strap_rb_o), 8'(~s));
      check(sel_valid_o == 1'b1, "R9 valid sticky", 8'(sel_valid_o), 8'h1);
   endtask

   task automatic t_sw_mode();
      logic [7:0] pat [7] = '{8'h88, 8'h0C, 8'h48, 8'h28, 8'h18, 8'hFF, 8'h08};
      logic [4:0] exp [7] = '{5'h10, 5'h08, 5'h04, 5'h02, 5'h01, 5'h1F, 5'h00};
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         ctrl0_i = pat[i];
         #0.5;
         check(sel_code_o == exp[i], "R6 R10 sw code", 8'(sel_code_o), 8'(exp[i]));
      end
   endtask

   task automatic t_sw_before_capture();
      apply_reset(4'h5);
      ctrl0_i = 8'hA8;  // S4=1, S1=1 -> 10010
      #1;
      check(sel_code_o == 5'h12, "R6 sw before capture", 8'(sel_code_o), 8'h12);
      check(sel_valid_o == 1'b0, "R6 still settling", 8'(sel_valid_o), 8'h0);
      ctrl0_i = 8'h00;
   endtask

   task automatic t_decode();
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         ctrl0_i = 8'(v);
         #0.5;
         check(spread_en_o == v[1], "R8 spread", 8'(spread_en_o), 8'(v[1]));
         check(test_mode_o == v[0], "R8 test", 8'(test_mode_o), 8'(v[0]));
      end
      ctrl0_i = 8'h00;
   endtask

   initial begin
      fork
         begin
            t_reset_state();
            t_settle(4'hA);
            t_hw_mode(4'hA);
            t_frozen(4'hA);
            t_sw_mode();
            t_decode();
            t_settle(4'h5);       // R9 rearm with new straps
            t_hw_mode(4'h5);
            t_settle(4'h0);       // R3 unstrapped pins read 0
            t_hw_mode(4'h0);
            t_sw_before_capture();
            t_settle(4'hF);
            t_hw_mode(4'hF);
            t_frozen(4'hF);
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule